// File: doc/BRIEF.md
# HDLC Transmit FIFO Controller

This block is the transmit side of one channel of a bit-serial framing engine. A host loads transmit data in chunks through a small write window. Each chunk has a length code, a command byte and up to 32 data bytes. The block turns the chunks into a serial bit stream. In HDLC mode it adds flag delimiting, zero-bit insertion and an optional CRC-16 trailer. In transparent mode it sends the bytes as they are, with no framing.

A chunk becomes ready for the serializer once the host has written as many data bytes as the length code asks for. When the serializer has taken the last byte of a chunk, the block raises a "pool ready" flag so the host can load the next chunk. If an HDLC frame is still open, has no end-of-message marker yet, and no chunk is ready when the next byte is due, the block aborts the frame and raises an underrun flag. The host then resets the transmitter and sends the whole frame again from its first byte. The line advances one bit for each pulse of a bit strobe supplied from outside.

Top module: `hdlc_tx_fifo_ctrl`

## Requirements
- R1: After reset, `tx_line` and `loop_line` are 1, `host_stat` is 0 and `irq` is 0. While neither framing mode bit is set, the line stays at 1.
- R2: `host_sel` picks the target of a host write: 0 is the command byte, 1 is the length code (bits 5:0, where 0 means 32 bytes), 2 is the mode byte and 3 is a data byte. A chunk is committed when the number of data bytes written equals the length. Data writes are ignored while a committed chunk is still being sent, and while the transmitter reset is held.
- R3: HDLC mode is mode bit 0. The line carries 0x7E flags between frames. Bytes are sent LSB first. A 0 is inserted after every run of five 1s in the data and CRC bits.
- R4: When mode bit 3 is set, a frame ends with the ones' complement of the reflected CCITT CRC (polynomial 0x8408, start value 0xFFFF), low byte first. When mode bit 3 is clear, no trailer is sent.
- R5: A chunk written while command bit 0 (end of message) is clear continues the open frame. The chunk committed while that bit is set closes the frame.
- R6: Status bit 7 (pool ready) is set when the serializer takes the last byte of a chunk, and when command bit 7 goes from 1 to 0.
- R7: In HDLC mode, if a frame is open, the next byte is due and no chunk is committed, status bit 6 (underrun) is set. The line is then held at 1 until the transmitter is reset. After the reset, a resent frame is transmitted correctly.
- R8: A host status read (`host_rd`) clears both status flags. A flag event in the same cycle takes priority over the clear. `irq` is the OR of the two flags.
- R9: Mode bit 1 selects transparent mode and takes precedence over bit 0. Bytes are sent LSB first with no flags, no bit stuffing and no CRC. End of message is ignored. 0xFF is sent when no chunk is ready, and no underrun is ever raised.
- R10: Mode bit 7 sends the serial stream to `loop_line` and holds `tx_line` at 1.
- R11: While command bit 7 is set, the serial stream is 1 and any partly written or committed chunk is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 2 | Write target: 0 command, 1 length, 2 mode, 3 data |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | Status read strobe; clears the flags |
| host_stat | output | 8 | Bit 7 pool ready, bit 6 underrun, other bits 0 |
| irq | output | 1 | Interrupt request |
| bit_en | input | 1 | Line bit strobe |
| tx_line | output | 1 | Serial line output |
| loop_line | output | 1 | Loopback output of the serial stream |

## Verification
The bench uses the default 32-byte pool with a 6-bit length code. With this setting it can sweep every legal chunk length, from 1 up to the zero code for 32, and decode each frame with its own flag hunter, bit destuffer and CRC model. The same pool size lets three chunks form a 71-byte frame. The bench runs the bit strobe at one bit per 4 clocks for the sweep, which makes underruns easy to provoke. It runs the strobe at one bit per 16 clocks for the multi-chunk frame, so the host has time to refill between chunks.

// File: rtl/hdlc_txf_pkg.sv
package hdlc_txf_pkg;
  typedef enum logic [2:0] {K_IDLE, K_FLAG, K_DATA, K_CRC_LO, K_CRC_HI, K_HALT} kind_e;

  localparam logic [7:0]  FLAG_BYTE  = 8'h7E;
  localparam logic [15:0] CRC_POLY_R = 16'h8408;
  localparam logic [15:0] CRC_SEED   = 16'hFFFF;

  localparam logic [1:0] SEL_CMD  = 2'd0;
  localparam logic [1:0] SEL_LEN  = 2'd1;
  localparam logic [1:0] SEL_MODE = 2'd2;
  localparam logic [1:0] SEL_DATA = 2'd3;

  localparam int CMD_EOM    = 0;
  localparam int CMD_XRST   = 7;
  localparam int MODE_HDLC  = 0;
  localparam int MODE_TRANS = 1;
  localparam int MODE_CRC16 = 3;
  localparam int MODE_LOOP  = 7;

  // one reflected CRC step for a single transmitted bit
  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    return (c >> 1) ^ (fb ? CRC_POLY_R : 16'h0000);
  endfunction
endpackage

// File: rtl/hdlc_txf_buffer.sv
module hdlc_txf_buffer #(
  parameter int DEPTH = 32,
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xrst,
  input  logic             wr_en,
  input  logic [7:0]       wdata,
  input  logic [LEN_W-1:0] len_code,
  input  logic             eom_in,
  input  logic             pop,
  output logic             full,
  output logic [7:0]       rdata,
  output logic             rd_last,
  output logic             chunk_eom,
  output logic             drain
);
  localparam int PTR_W = $clog2(DEPTH) + 1;

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr, len_q;
  logic             accept;

  // length code 0 (or anything past the pool) means a full pool
  function automatic logic [PTR_W-1:0] len_eff(input logic [LEN_W-1:0] code);
    if (code == '0 || int'(code) > DEPTH) return PTR_W'(DEPTH);
    return PTR_W'(code);
  endfunction

  assign accept  = wr_en && !full && !xrst;
  assign rdata   = mem[rptr[PTR_W-2:0]];
  assign rd_last = (rptr + 1'b1) == len_q;
  assign drain   = pop && full && rd_last;

  always_ff @(posedge clk) begin
    if (accept) mem[wptr[PTR_W-2:0]] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr      <= '0;
      rptr      <= '0;
      full      <= 1'b0;
      chunk_eom <= 1'b0;
      len_q     <= PTR_W'(DEPTH);
    end else if (xrst) begin
      wptr <= '0;
      rptr <= '0;
      full <= 1'b0;
    end else begin
      if (accept) begin
        wptr <= wptr + 1'b1;
        if ((wptr + 1'b1) == len_eff(len_code)) begin
          full      <= 1'b1;
          chunk_eom <= eom_in;
          len_q     <= len_eff(len_code);
          rptr      <= '0;
        end
      end
      if (pop && full) begin
        rptr <= rptr + 1'b1;
        if (rd_last) begin
          full <= 1'b0;
          wptr <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/hdlc_txf_serializer.sv
module hdlc_txf_serializer
  import hdlc_txf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xrst,
  input  logic       bit_en,
  input  logic       hdlc_en,
  input  logic       trans_en,
  input  logic       crc_en,
  input  logic       buf_full,
  input  logic [7:0] buf_data,
  input  logic       buf_last,
  input  logic       buf_eom,
  output logic       pop,
  output logic       under_evt,
  output logic       stuff_evt,
  output logic [2:0] ones_run,
  output logic       ser_bit
);
  kind_e       kind, nk;
  logic [7:0]  sh, nsh;
  logic [2:0]  bcnt, ones;
  logic [15:0] crc, crc_nx;
  logic        last_eom, ser_q;
  logic        trans_mode, hdlc_mode, counts, byte_end;
  logic        do_pop, und, crc_rst;

  assign trans_mode = trans_en;
  assign hdlc_mode  = hdlc_en && !trans_en;
  assign counts     = hdlc_mode && (kind == K_DATA || kind == K_CRC_LO || kind == K_CRC_HI);
  assign stuff_evt  = bit_en && (ones == 3'd5);
  assign byte_end   = bit_en && !stuff_evt && (bcnt == 3'd7);
  assign crc_nx     = crc_step(crc, sh[0]);
  assign pop        = byte_end && do_pop;
  assign under_evt  = byte_end && und;
  assign ones_run   = ones;
  assign ser_bit    = ser_q;

  // choice of the next byte at a byte boundary
  always_comb begin
    nk      = kind;
    nsh     = 8'hFF;
    do_pop  = 1'b0;
    und     = 1'b0;
    crc_rst = 1'b0;
    if (kind == K_HALT) begin
      nk = K_HALT;
    end else if (trans_mode) begin
      if (buf_full) begin
        nk = K_DATA; nsh = buf_data; do_pop = 1'b1;
      end else begin
        nk = K_IDLE;
      end
    end else if (hdlc_mode) begin
      unique case (kind)
        K_DATA: begin
          if (last_eom) begin
            if (crc_en) begin
              nk = K_CRC_LO; nsh = ~crc_nx[7:0];
            end else begin
              nk = K_FLAG; nsh = FLAG_BYTE; crc_rst = 1'b1;
            end
          end else if (buf_full) begin
            nk = K_DATA; nsh = buf_data; do_pop = 1'b1;
          end else begin
            nk = K_HALT; und = 1'b1;
          end
        end
        K_CRC_LO: begin
          nk = K_CRC_HI; nsh = ~crc[15:8];
        end
        K_FLAG: begin
          if (buf_full) begin
            nk = K_DATA; nsh = buf_data; do_pop = 1'b1;
          end else begin
            nk = K_FLAG; nsh = FLAG_BYTE; crc_rst = 1'b1;
          end
        end
        default: begin
          nk = K_FLAG; nsh = FLAG_BYTE; crc_rst = 1'b1;
        end
      endcase
    end else begin
      nk = K_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind <= K_IDLE; sh <= 8'hFF; bcnt <= '0; ones <= '0;
      crc <= CRC_SEED; last_eom <= 1'b0; ser_q <= 1'b1;
    end else if (xrst) begin
      kind <= K_IDLE; sh <= 8'hFF; bcnt <= '0; ones <= '0;
      crc <= CRC_SEED; last_eom <= 1'b0; ser_q <= 1'b1;
    end else if (bit_en) begin
      if (stuff_evt) begin
        ser_q <= 1'b0;
        ones  <= '0;
      end else begin
        ser_q <= sh[0];
        ones  <= (counts && sh[0]) ? ones + 3'd1 : 3'd0;
        if (kind == K_DATA && hdlc_mode) crc <= crc_nx;
        if (bcnt == 3'd7) begin
          kind     <= nk;
          sh       <= nsh;
          bcnt     <= '0;
          last_eom <= do_pop ? (buf_last && buf_eom) : 1'b0;
          if (crc_rst) crc <= CRC_SEED;
        end else begin
          sh   <= sh >> 1;
          bcnt <= bcnt + 3'd1;
        end
      end
    end
  end
endmodule

// File: rtl/hdlc_tx_fifo_ctrl.sv
module hdlc_tx_fifo_ctrl
  import hdlc_txf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LEN_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_we,
  input  logic [1:0] host_sel,
  input  logic [7:0] host_wdata,
  input  logic       host_rd,
  output logic [7:0] host_stat,
  output logic       irq,
  input  logic       bit_en,
  output logic       tx_line,
  output logic       loop_line
);
  logic             cmd_eom, xrst, xrst_d;
  logic [LEN_W-1:0] len_code;
  logic             m_hdlc, m_trans, m_crc, m_loop;
  logic             pool_rdy_q, under_q;
  logic             data_we, xrst_fall;
  logic             buf_full, buf_last, buf_eom, drain_evt, pop;
  logic [7:0]       buf_data;
  logic             under_evt, stuff_evt, ser_bit;
  logic [2:0]       ones_run;

  assign data_we   = host_we && (host_sel == SEL_DATA);
  assign xrst_fall = xrst_d && !xrst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_eom <= 1'b0; xrst <= 1'b0; xrst_d <= 1'b0;
      len_code <= '0;
      m_hdlc <= 1'b0; m_trans <= 1'b0; m_crc <= 1'b0; m_loop <= 1'b0;
      pool_rdy_q <= 1'b0; under_q <= 1'b0;
    end else begin
      xrst_d <= xrst;
      if (host_we && host_sel == SEL_CMD) begin
        cmd_eom <= host_wdata[CMD_EOM];
        xrst    <= host_wdata[CMD_XRST];
      end
      if (host_we && host_sel == SEL_LEN) len_code <= host_wdata[LEN_W-1:0];
      if (host_we && host_sel == SEL_MODE) begin
        m_hdlc  <= host_wdata[MODE_HDLC];
        m_trans <= host_wdata[MODE_TRANS];
        m_crc   <= host_wdata[MODE_CRC16];
        m_loop  <= host_wdata[MODE_LOOP];
      end
      pool_rdy_q <= (pool_rdy_q && !host_rd) || drain_evt || xrst_fall;
      under_q    <= (under_q && !host_rd) || under_evt;
    end
  end

  hdlc_txf_buffer #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .xrst(xrst), .wr_en(data_we), .wdata(host_wdata),
    .len_code(len_code), .eom_in(cmd_eom), .pop(pop), .full(buf_full),
    .rdata(buf_data), .rd_last(buf_last), .chunk_eom(buf_eom), .drain(drain_evt)
  );

  hdlc_txf_serializer u_ser (
    .clk(clk), .rst_n(rst_n), .xrst(xrst), .bit_en(bit_en),
    .hdlc_en(m_hdlc), .trans_en(m_trans), .crc_en(m_crc),
    .buf_full(buf_full), .buf_data(buf_data), .buf_last(buf_last), .buf_eom(buf_eom),
    .pop(pop), .under_evt(under_evt), .stuff_evt(stuff_evt),
    .ones_run(ones_run), .ser_bit(ser_bit)
  );

  assign host_stat = {pool_rdy_q, under_q, 6'b0};
  assign irq       = pool_rdy_q || under_q;
  assign tx_line   = m_loop ? 1'b1 : ser_bit;
  assign loop_line = m_loop ? ser_bit : 1'b1;
endmodule

// File: rtl/hdlc_txf_checker.sv
module hdlc_txf_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       stuff_evt,
  input logic [2:0] ones_run,
  input logic       ser_bit,
  input logic       drain_evt,
  input logic       under_evt,
  input logic       xrst,
  input logic       host_rd,
  input logic       stat_rdy,
  input logic       stat_under
);
  AST_STUFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_evt |=> !ser_bit); // R3
  AST_RUN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ones_run <= 3'd5); // R3
  AST_DRAIN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    drain_evt |=> stat_rdy); // R6
  AST_UNDER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    under_evt |=> stat_under); // R7
  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !under_evt) |=> !stat_under); // R8
  AST_XRST_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    xrst |=> ser_bit); // R11
endmodule

bind hdlc_tx_fifo_ctrl hdlc_txf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .stuff_evt(stuff_evt), .ones_run(ones_run),
  .ser_bit(ser_bit), .drain_evt(drain_evt), .under_evt(under_evt), .xrst(xrst),
  .host_rd(host_rd), .stat_rdy(host_stat[7]), .stat_under(host_stat[6])
);

// File: tb/tb_hdlc_tx_fifo_ctrl.sv
module tb_hdlc_tx_fifo_ctrl;
  logic       clk = 0, rst_n = 0, host_we = 0, host_rd = 0, bit_en = 0;
  logic [1:0] host_sel = 0;
  logic [7:0] host_wdata = 0;
  logic [7:0] host_stat;
  logic       irq, tx_line, loop_line;

  int n_chk = 0, n_fail = 0;
  int div = 4, dcnt = 0;
  logic log_on = 0, log_loop = 0, saw_tx0 = 0;
  logic lg [0:4095];
  int   log_n = 0;
  logic [7:0] fr [0:95];
  int   fr_len;
  logic [7:0] ex [0:95];
  int   ex_len;

  always #10 clk = ~clk;

  hdlc_tx_fifo_ctrl dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rd(host_rd), .host_stat(host_stat), .irq(irq),
    .bit_en(bit_en), .tx_line(tx_line), .loop_line(loop_line)
  );

  // bit strobe generator and line logger
  always @(negedge clk) begin
    if (bit_en && log_on && log_n < 4096) begin
      lg[log_n] = log_loop ? loop_line : tx_line;
      log_n++;
    end
    if (log_on && !tx_line) saw_tx0 = 1;
    if (dcnt >= div - 1) begin dcnt = 0; bit_en = 1; end
    else begin dcnt++; bit_en = 0; end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); host_we = 1; host_sel = sel; host_wdata = d;
    @(negedge clk); host_we = 0;
  endtask

  task automatic rd_stat();
    @(negedge clk); host_rd = 1;
    @(negedge clk); host_rd = 0;
  endtask

  task automatic wait_bits(input int n);
    repeat (n * div) @(negedge clk);
  endtask

  task automatic wait_flag(input int bitn, input int maxc, output bit ok);
    ok = 0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (host_stat[bitn]) begin ok = 1; break; end
    end
  endtask

  task automatic xrst_pulse();
    wr(2'd0, 8'h80);
    wr(2'd0, 8'h00);
    repeat (2) @(negedge clk);
    rd_stat();
  endtask

  function automatic logic [7:0] dat(input int i, input int seed);
    if (i % 3 == 1) return 8'hFF;
    return 8'((seed * 29 + i * 53) & 255);
  endfunction

  // independent receiver: flag hunt, destuffing, abort on seven ones
  task automatic decode();
    int ones = 0, nb = 0, fb;
    bit synced = 0;
    logic bits [0:1023];
    fr_len = -1;
    for (int i = 0; i < log_n && fr_len < 0; i++) begin
      if (lg[i]) begin
        ones++;
        if (ones >= 7) begin nb = 0; synced = 0; end
        else if (nb < 1024) begin bits[nb] = 1; nb++; end
      end else begin
        if (ones == 5) begin
          ones = 0;
        end else if (ones == 6) begin
          fb = nb - 7;
          if (synced && fb >= 8 && fb % 8 == 0) begin
            fr_len = fb / 8;
            for (int k = 0; k < fr_len; k++)
              for (int j = 0; j < 8; j++) fr[k][j] = bits[8*k + j];
          end
          synced = 1; nb = 0; ones = 0;
        end else begin
          if (nb < 1024) begin bits[nb] = 0; nb++; end
          ones = 0;
        end
      end
    end
  endtask

  task automatic add_crc();
    logic [15:0] c;
    logic fb;
    c = 16'hFFFF;
    for (int i = 0; i < ex_len; i++)
      for (int j = 0; j < 8; j++) begin
        fb = c[0] ^ ex[i][j];
        c = c >> 1;
        if (fb) c = c ^ 16'h8408;
      end
    ex[ex_len] = ~c[7:0];
    ex[ex_len + 1] = ~c[15:8];
    ex_len += 2;
  endtask

  task automatic cmp_frame(input string req);
    int bad = 0;
    if (fr_len == ex_len)
      for (int k = 0; k < ex_len; k++) if (fr[k] !== ex[k]) bad++;
    chk(fr_len == ex_len && bad == 0, req, fr_len * 256 + bad, ex_len * 256);
  endtask

  // one single-chunk frame closed by end of message
  task automatic one_frame(input int len, input int seed, input bit crc, input string req);
    bit ok;
    log_n = 0; log_on = 1;
    wr(2'd0, 8'h01);
    wr(2'd1, (len == 32) ? 8'd0 : 8'(len));
    ex_len = len;
    for (int i = 0; i < len; i++) begin
      ex[i] = dat(i, seed);
      wr(2'd3, ex[i]);
    end
    if (crc) add_crc();
    wait_flag(7, (len + 4) * 8 * div + 400, ok);
    chk(ok, req, 0, 1);
    wait_bits(48);
    log_on = 0;
    decode();
    cmp_frame(req);
    rd_stat();
  endtask

  initial begin
    bit ok;
    int p;
    logic [7:0] tb_byte;
    logic [7:0] tx_exp [0:5];
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(tx_line === 1 && loop_line === 1, "R1 line idle", {tx_line, loop_line}, 2'b11);
    chk(host_stat === 8'h00 && irq === 0, "R1 status", {irq, host_stat}, 0);
    log_n = 0; log_on = 1; saw_tx0 = 0;
    wait_bits(20);
    log_on = 0;
    chk(!saw_tx0, "R1 no mode keeps mark", saw_tx0, 0);

    // HDLC with CRC-16
    wr(2'd2, 8'h09);
    wr(2'd0, 8'h80);
    wait_bits(3);
    chk(tx_line === 1, "R11 mark during reset", tx_line, 1);
    wr(2'd0, 8'h00);
    repeat (2) @(negedge clk);
    chk(host_stat[7] === 1, "R6 ready on reset release", host_stat, 8'h80);
    rd_stat();
    chk(host_stat === 8'h00 && irq === 0, "R8 read clears", host_stat, 0);

    // sweep of every chunk length, code 0 at 32
    for (int len = 1; len <= 32; len++)
      one_frame(len, len, 1, (len == 32) ? "R2 R3 R4 len32" : "R3 R4 sweep");

    // no CRC trailer
    wr(2'd2, 8'h01);
    one_frame(3, 77, 0, "R4 no trailer");
    wr(2'd2, 8'h09);

    // writes beyond a committed chunk are dropped
    log_n = 0; log_on = 1;
    wr(2'd0, 8'h01);
    wr(2'd1, 8'd4);
    ex_len = 4;
    for (int i = 0; i < 4; i++) begin ex[i] = 8'h10 + 8'(i); wr(2'd3, ex[i]); end
    for (int i = 0; i < 3; i++) wr(2'd3, 8'hAA);
    add_crc();
    wait_flag(7, 2000, ok);
    wait_bits(48);
    log_on = 0;
    decode();
    cmp_frame("R2 extra writes ignored");
    rd_stat();

    // three chunks in one frame
    div = 16;
    log_n = 0; log_on = 1;
    ex_len = 0;
    for (int c = 0; c < 3; c++) begin
      wr(2'd0, (c == 2) ? 8'h01 : 8'h00);
      wr(2'd1, (c == 2) ? 8'd7 : 8'd0);
      for (int i = 0; i < ((c == 2) ? 7 : 32); i++) begin
        ex[ex_len] = dat(ex_len, 5);
        wr(2'd3, ex[ex_len]);
        ex_len++;
      end
      wait_flag(7, 12000, ok);
      chk(ok, "R6 ready per chunk", ok, 1);
      chk(host_stat[6] === 0, "R5 no underrun between chunks", host_stat, 8'h80);
      rd_stat();
    end
    add_crc();
    wait_bits(48);
    log_on = 0;
    decode();
    cmp_frame("R5 multi chunk frame");

    // underrun and recovery
    div = 4;
    wr(2'd0, 8'h00);
    wr(2'd1, 8'd0);
    for (int i = 0; i < 32; i++) wr(2'd3, dat(i, 9));
    wait_flag(6, 3000, ok);
    chk(ok, "R7 underrun flag", host_stat, 8'h40);
    chk(irq === 1, "R8 irq on flag", irq, 1);
    log_n = 0; log_on = 1; saw_tx0 = 0;
    wait_bits(20);
    log_on = 0;
    chk(!saw_tx0, "R7 line held at 1", saw_tx0, 0);
    rd_stat();
    chk(host_stat === 8'h00 && irq === 0, "R8 read clears both", host_stat, 0);
    xrst_pulse();
    one_frame(10, 3, 1, "R7 resend after reset");

    // transparent mode, both mode bits set
    wr(2'd2, 8'h03);
    xrst_pulse();
    log_n = 0; log_on = 1;
    wait_bits(10);
    wr(2'd0, 8'h01);
    wr(2'd1, 8'd4);
    tx_exp[0] = 8'h02; tx_exp[1] = 8'hFF; tx_exp[2] = 8'hFF; tx_exp[3] = 8'h81;
    tx_exp[4] = 8'hFF; tx_exp[5] = 8'hFF;
    for (int i = 0; i < 4; i++) wr(2'd3, tx_exp[i]);
    wait_flag(7, 1000, ok);
    wait_bits(40);
    log_on = 0;
    p = -1;
    for (int i = 0; i < log_n; i++) if (p < 0 && lg[i] === 0) p = i;
    chk(p >= 8, "R9 idle 0xFF before data", p, 8);
    for (int k = 0; k < 6; k++) begin
      for (int j = 0; j < 8; j++) tb_byte[j] = (p >= 0 && p + 8*k + j < log_n) ? lg[p + 8*k + j] : 1'b0;
      chk(tb_byte === tx_exp[k], "R9 transparent byte", tb_byte, tx_exp[k]);
    end
    chk(host_stat[6] === 0, "R9 no underrun", host_stat, 8'h80);
    rd_stat();

    // loopback
    wr(2'd2, 8'h89);
    xrst_pulse();
    log_loop = 1; saw_tx0 = 0;
    one_frame(3, 11, 1, "R10 loop frame");
    chk(!saw_tx0, "R10 tx_line held", saw_tx0, 0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule